// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel of a general purpose timer. It sits on an 8-bit register bus and watches a 16-bit free-running count that comes from outside the block. The count comes with a one-cycle pulse that marks each new value. When a marked count equals the stored 16-bit compare value, the block copies a programmed level onto its output pin and raises a compare flag. The flag can request an interrupt.

Software loads the compare value one byte at a time. Writing the upper byte holds off matching until the lower byte has also been written, so a half-updated value never produces a false match. Software clears the flag with a two-step sequence: it reads the status register while the flag is set, and then it reads or writes the lower compare byte.

The register map is as follows. Address 0x16 holds the upper compare byte and 0x17 holds the lower one. The control register sits at 0x12 and the status register at 0x13.

Top module: `oc_unit`

## Requirements
- R1: A match occurs when the count pulse is high, the count equals {upper byte, lower byte}, and matching is not held off. The compare flag reads 1 from the clock edge that registers the match.
- R2: On each match the output pin takes the value of control bit 0 (the level bit). This happens even when the flag is already set.
- R3: A write to the upper compare byte (0x16) blocks all matches until the next write to the lower compare byte (0x17).
- R4: Reading status (0x13) while the flag is set arms a clear. The next read or write of 0x17 then clears the flag. Status bit 6 shows the flag, and all other status bits read 0.
- R5: A read or write of 0x17 with no armed status read leaves the flag unchanged.
- R6: If a match coincides with the clearing access, the flag stays 1.
- R7: The interrupt output equals the flag ANDed with control bit 6 (the interrupt enable).
- R8: Reset drives the pin, the flag, the control bits and the arm state to 0, and releases the hold-off. The two compare bytes keep their contents through reset.
- R9: Both compare bytes and the control register (bits 0 and 6) can be written and read back. Unmapped addresses read 0.
- R10: When the count pulse is low, an equal count produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Free-running count value |
| cnt_tick_i | input | 1 | High for the cycle in which a new count value appears |
| bus_addr_i | input | 8 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| cmp_pin_o | output | 1 | Output compare level latch |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The bench drives a count that equals the compare value while the upper byte has been written but the lower byte has not. A design without the interlock would set the flag there. The bench also sends a lower-byte access with no armed status read; a design that cleared the flag on any lower-byte access would drop it. It then lines up a match with the clearing access in the same cycle; a design that gave the clear priority would lose the event. Finally, it checks that the compare bytes survive a reset while the hold-off does not, and that a second match with the flag already set still moves the pin.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int LEVEL_BIT = 0;
    localparam int IE_BIT    = 6;
    localparam int FLAG_BIT  = 6;

    typedef struct packed {
        logic level;
        logic irq_en;
    } ctl_t;

    typedef struct packed {
        logic flag;
        logic arm;
        logic pin;
    } evt_t;
endpackage

// File: rtl/oc_regfile.sv
module oc_regfile
    import oc_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h17,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h12,
    parameter logic [ADDR_W-1:0] STS_ADDR = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    input  logic              flag_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic [CNT_W-1:0]  cmp_o,
    output ctl_t              ctl_o,
    output logic              hi_wr_o,
    output logic              lo_wr_o,
    output logic              lo_acc_o,
    output logic              sts_rd_o
);
    localparam int NB = CNT_W / BUS_W;

    logic [NB-1:0] sel;
    ctl_t ctl_d, ctl_q;

    // byte g of the compare value lives at LO_ADDR - g (upper byte at lower address)
    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [BUS_W-1:0] byte_d, byte_q;
        assign sel[g] = (bus_addr_i == ADDR_W'(int'(LO_ADDR) - g));
        always_comb begin
            byte_d = byte_q;
            if (bus_wr_i && sel[g]) byte_d = bus_wdata_i;
        end
        // compare bytes deliberately keep their contents through reset
        always_ff @(posedge clk) begin
            byte_q <= byte_d;
        end
        assign cmp_o[g*BUS_W +: BUS_W] = byte_q;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr_i && bus_addr_i == CTL_ADDR) begin
            ctl_d.level  = bus_wdata_i[LEVEL_BIT];
            ctl_d.irq_en = bus_wdata_i[IE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (sel[i]) bus_rdata_o = cmp_o[i*BUS_W +: BUS_W];
        end
        if (bus_addr_i == CTL_ADDR) begin
            bus_rdata_o[LEVEL_BIT] = ctl_q.level;
            bus_rdata_o[IE_BIT]    = ctl_q.irq_en;
        end
        if (bus_addr_i == STS_ADDR) bus_rdata_o[FLAG_BIT] = flag_i;
    end

    assign ctl_o    = ctl_q;
    assign hi_wr_o  = bus_wr_i && (|sel[NB-1:1]);
    assign lo_wr_o  = bus_wr_i && sel[0];
    assign lo_acc_o = (bus_wr_i || bus_rd_i) && sel[0];
    assign sts_rd_o = bus_rd_i && (bus_addr_i == STS_ADDR);

    // R9
    ctl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == CTL_ADDR) |=> (ctl_q.level == $past(bus_wdata_i[LEVEL_BIT])));
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             hold_set_i,
    input  logic             hold_clr_i,
    output logic             hit_o
);
    typedef struct packed {
        logic hold;
    } mst_t;

    mst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_set_i)      st_d.hold = 1'b1;
        else if (hold_clr_i) st_d.hold = 1'b0;
        hit_o = tick_i && (cnt_i == cmp_i) && !st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_set_i |=> !hit_o);

    // R10
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> !hit_o);
endmodule

// File: rtl/oc_flag.sv
module oc_flag
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic level_i,
    input  logic sts_rd_i,
    input  logic lo_acc_i,
    output logic flag_o,
    output logic pin_o
);
    evt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_i) st_d.pin = level_i;
        if (lo_acc_i)                st_d.arm = 1'b0;
        else if (sts_rd_i && st_q.flag) st_d.arm = 1'b1;
        if (hit_i)                       st_d.flag = 1'b1;
        else if (lo_acc_i && st_q.arm)   st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign pin_o  = st_q.pin;

    // R2
    pin_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (pin_o == $past(level_i)));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_o);

    // R4
    clear_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> ($past(lo_acc_i) && $past(st_q.arm)));

    // R5
    no_arm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_acc_i && !st_q.arm && flag_o) |=> flag_o);
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cnt_tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              cmp_pin_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] cmp;
    ctl_t ctl;
    logic hi_wr, lo_wr, lo_acc, sts_rd, hit, flag;

    oc_regfile #(.BUS_W(BUS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .bus_wdata_i(bus_wdata_i), .flag_i(flag), .bus_rdata_o(bus_rdata_o),
        .cmp_o(cmp), .ctl_o(ctl), .hi_wr_o(hi_wr), .lo_wr_o(lo_wr),
        .lo_acc_o(lo_acc), .sts_rd_o(sts_rd)
    );

    oc_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .tick_i(cnt_tick_i),
        .cmp_i(cmp), .hold_set_i(hi_wr), .hold_clr_i(lo_wr), .hit_o(hit)
    );

    oc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .level_i(ctl.level),
        .sts_rd_i(sts_rd), .lo_acc_i(lo_acc), .flag_o(flag), .pin_o(cmp_pin_o)
    );

    assign irq_o = flag && ctl.irq_en;

    // R1
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick_i && cnt_i == cmp && $past(rst_n) && !$past(hi_wr) && hit) |=> flag);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl.irq_en);
endmodule

// File: tb/tb_oc_unit.sv
module tb_oc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic       tick = 1'b0;
    logic [7:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pin, irq;

    int n_tests = 0, n_fail = 0;

    // reference state
    logic [7:0] m_hi = '0, m_lo = '0;
    bit m_level, m_ie, m_flag, m_arm, m_pin, m_hold;

    always #2.5 clk = ~clk;

    oc_unit dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_tick_i(tick),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .cmp_pin_o(pin), .irq_o(irq)
    );

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        case (a)
            8'h16: return m_hi;
            8'h17: return m_lo;
            8'h12: return {1'b0, 1'(m_ie), 5'b0, 1'(m_level)};
            8'h13: return {1'b0, 1'(m_flag), 6'b0};
            default: return 8'h00;
        endcase
    endfunction

    // one clock: drive, compare against reference, advance reference at the edge
    task automatic step(string tag, logic [7:0] a, bit w, bit r, logic [7:0] d,
                        logic [15:0] c, bit t);
        bit hit;
        addr = a; wr = w; rd = r; wdata = d; cnt = c; tick = t;
        #1;
        check(tag, "pin", 16'(pin), 16'(m_pin));
        check("R7", "irq", 16'(irq), 16'(m_flag & m_ie));
        if (r) check(tag, "rdata", 16'(rdata), 16'(exp_rd(a)));
        @(posedge clk);
        hit = t && (c == {m_hi, m_lo}) && !m_hold;
        if (hit) m_pin = m_level;
        if (hit) m_flag = 1;
        else if (w || r) begin
            if (a == 8'h17 && m_arm) m_flag = 0;
        end
        if ((w || r) && a == 8'h17) m_arm = 0;
        else if (r && a == 8'h13 && m_flag) m_arm = 1;
        if (w && a == 8'h16) m_hold = 1;
        if (w && a == 8'h17) m_hold = 0;
        if (w && a == 8'h16) m_hi = d;
        if (w && a == 8'h17) m_lo = d;
        if (w && a == 8'h12) begin m_level = d[0]; m_ie = d[6]; end
        @(negedge clk);
        addr = '0; wr = 0; rd = 0; tick = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(posedge clk); @(posedge clk);
        m_level = 0; m_ie = 0; m_flag = 0; m_arm = 0; m_pin = 0; m_hold = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr8(string tag, logic [7:0] a, logic [7:0] d);
        step(tag, a, 1, 0, d, 16'h0, 0);
    endtask

    task automatic rd8(string tag, logic [7:0] a);
        step(tag, a, 0, 1, 8'h00, 16'h0, 0);
    endtask

    task automatic tk(string tag, logic [15:0] c);
        step(tag, 8'h00, 0, 0, 8'h00, c, 1);
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R8 reset state
        check("R8", "pin after reset", 16'(pin), 16'h0);
        check("R8", "irq after reset", 16'(irq), 16'h0);
        rd8("R8", 8'h13);
        rd8("R8", 8'h12);

        // R9 register access
        wr8("R9", 8'h16, 8'h12);
        wr8("R9", 8'h17, 8'h34);
        wr8("R9", 8'h12, 8'h41);
        rd8("R9", 8'h16); rd8("R9", 8'h17); rd8("R9", 8'h12); rd8("R9", 8'h20);

        // R1 R2 R7 count sweep through the compare value
        for (int i = 16'h1230; i < 16'h1237; i++) tk("R1", 16'(i));
        rd8("R1", 8'h13);
        check("R2", "pin after match", 16'(pin), 16'h1);

        // R4 clear sequence by low read
        rd8("R4", 8'h13);
        rd8("R4", 8'h17);
        rd8("R4", 8'h13);

        // R1 partial matches must not hit
        tk("R1", 16'h0034); tk("R1", 16'h1200); tk("R1", 16'h1334);
        rd8("R1", 8'h13);

        // R10 equal count without tick
        step("R10", 8'h00, 0, 0, 8'h00, 16'h1234, 0);
        rd8("R10", 8'h13);

        // R5 low access without arming keeps flag
        tk("R5", 16'h1234);
        wr8("R5", 8'h17, 8'h34);
        rd8("R5", 8'h17);
        rd8("R5", 8'h13);
        // R4 clear via low write after arming
        wr8("R4", 8'h17, 8'h34);
        rd8("R4", 8'h13);

        // R3 interlock: upper write holds off matching
        wr8("R3", 8'h16, 8'h12);
        tk("R3", 16'h1234);
        rd8("R3", 8'h13);
        wr8("R3", 8'h17, 8'h34);
        tk("R3", 16'h1234);
        rd8("R3", 8'h13);

        // R2 second match with flag already set moves pin
        wr8("R2", 8'h12, 8'h40);
        tk("R2", 16'h1234);
        check("R2", "pin low after relatch", 16'(pin), 16'h0);

        // R6 match coincides with clearing access
        rd8("R6", 8'h13);
        step("R6", 8'h17, 0, 1, 8'h00, 16'h1234, 1);
        rd8("R6", 8'h13);
        check("R6", "irq stays", 16'(irq), 16'h1);

        // R7 interrupt disabled while flag set
        wr8("R7", 8'h12, 8'h01);
        check("R7", "irq masked", 16'(irq), 16'h0);

        // R8 retention and hold-off release across reset
        wr8("R8", 8'h17, 8'hA5);
        wr8("R8", 8'h16, 8'h5A);
        do_reset();
        rd8("R8", 8'h16);
        rd8("R8", 8'h17);
        rd8("R8", 8'h13);
        wr8("R8", 8'h12, 8'h01);
        tk("R8", 16'h5AA5);
        rd8("R8", 8'h13);
        check("R8", "pin after post-reset match", 16'(pin), 16'h1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule